// File: doc/BRIEF.md
# Selective Harmonic Elimination Gate Generator for Cascaded Five-Level Cells

This block drives the power switches of a single-phase multilevel inverter that is a series chain of five-level transistor-clamped H-bridge cells. Each cell puts out zero, plus or minus half of its DC supply, or plus or minus its full supply. A chain of N cells therefore gives 4N+1 output levels. The switching instants come from offline harmonic-elimination angles. Software turns these angles into amplitude thresholds (peak times the sine of each angle) and loads them through a small write port. The block never handles time-based angles.

A phase accumulator runs a quarter-wave sine table to make a reference at the frequency set by a tuning word. The block rectifies this reference and compares it with a low and a high threshold for every cell. Changing the frequency word therefore leaves the thresholds valid. Software assigns the sorted angles in interleaved order: cell r takes angle r as its low threshold and angle r+N as its high threshold, so the load is shared between cells. The half-cycle flag drives one bridge leg of every cell directly, and the other leg gets its complement. Comparator results give the clamp switch and the two full-level switches. A debug output reports the signed staircase level.

Top module: `she_gate_gen`

## Requirements
- R1: With N cells (default 2), `cell_gates` carries 5N bits. Cell c uses bits 5c to 5c+4, holding switches 1 to 5 from the least significant bit. The staircase covers -2N to +2N, which is 4N+1 levels, and both extremes are reached when every threshold is below the peak.
- R2: A 32-bit phase accumulator starts at 0 after reset and adds `freq_word` on every clock. The half-cycle flag is its most significant bit, so the flag toggles every 2^31/`freq_word` cycles.
- R3: The rectified reference takes table index phase[29:22], inverted when phase[30] is 1. Table entry k is floor(4095*16u(1024-u) / (5*1024^2 - 4u(1024-u))), where u = 2k+1.
- R4: For each cell, C1 = (magnitude >= low threshold) and C2 = (magnitude >= high threshold). The cell's step count is 2 if C2 is true, else 1 if C1 is true, else 0. This rule also holds when the high threshold is below the low threshold.
- R5: Switch 5 = C1 AND NOT C2. Switch 1 = C2 AND half flag. Switch 3 = C2 AND NOT half flag. Switch 5 is never on together with switch 1 or switch 3, and switch 1 is never on with switch 2, nor switch 3 with switch 4.
- R6: Switch 4 equals the half-cycle flag in every cell, and switch 2 is its complement.
- R7: Outputs seen after clock edge e follow the phase value held after edge e-2 and the active thresholds held after edge e-1.
- R8: Write port: `thr_addr` bit 0 chooses low (0) or high (1), and the higher bits choose the cell. A written value waits until the edge at which the lookup stage's half flag changes. At that edge all pending values of all cells become active together. Before then a write has no effect on the outputs.
- R9: While reset is high, all gates are 0 and the level is 0. Reset sets every threshold, pending and active, to 4095, so the staircase stays at 0 until thresholds are written and become active.
- R10: A new `freq_word` takes effect on the next clock with no change to the thresholds. The full staircase is still produced at the new frequency.
- R11: `level_dbg` is the sum of the step counts of all cells, negated when the half flag (switch 4) is set. It is registered together with the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 32 | Phase increment per clock |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | 2 | Threshold select: bit 0 low/high, upper bits cell |
| thr_data | input | 12 | Threshold value, unsigned |
| cell_gates | output | 10 | Five gate bits per cell |
| level_dbg | output | 4 | Signed staircase level (two's complement) |

## Verification
The gates and the level come from a two-register pipeline. A phase value is therefore seen at the outputs two edges after the accumulator holds it, and the bench compares the outputs 2 ns after every rising edge against a model whose phase is delayed by the same two stages. A threshold write is followed, up to the next half-flag change, by samples that must show the old thresholds. From the first sample after that change, the model switches to the new thresholds. Reset is checked on the first sample after the edge that sees it. A new frequency is checked through the spacing of switch-4 toggles once a full half-cycle has passed at that frequency.

// File: rtl/she_pkg.sv
`timescale 1ns/1ps
package she_pkg;

    // Gate bits of one cell, switch 1 in the least significant position
    typedef struct packed {
        logic s5;
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } gate_t;

    // Comparator results of one cell
    typedef struct packed {
        logic ge_lo;
        logic ge_hi;
    } cmp_t;

    // Rational sine approximation at the centre of table slot k of a
    // quarter wave with 'depth' slots, scaled to full amp_w range
    function automatic longint quarter_sine(input int k, input int depth, input int amp_w);
        longint p, u, full, num, den;
        p    = 4 * longint'(depth);
        u    = 2 * longint'(k) + 1;
        full = (longint'(1) << amp_w) - 1;
        num  = 16 * u * (p - u) * full;
        den  = 5 * p * p - 4 * u * (p - u);
        return num / den;
    endfunction

    function automatic gate_t gates_of(input cmp_t c, input logic half);
        gate_t g;
        g.s5 = c.ge_lo & ~c.ge_hi;
        g.s1 = c.ge_hi & half;
        g.s3 = c.ge_hi & ~half;
        g.s4 = half;
        g.s2 = ~half;
        return g;
    endfunction

    function automatic logic [1:0] steps_of(input cmp_t c);
        return c.ge_hi ? 2'd2 : (c.ge_lo ? 2'd1 : 2'd0);
    endfunction

endpackage

// File: rtl/she_phase_gen.sv
`timescale 1ns/1ps
module she_phase_gen #(
    parameter int PH_W   = 32,
    parameter int LUT_AW = 8,
    parameter int AMP_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  freq_word,
    output logic [AMP_W-1:0] mag_q,
    output logic             half_q,
    output logic             zero_cross
);
    localparam int DEPTH = 1 << LUT_AW;

    logic [PH_W-1:0]   acc_q;
    logic [AMP_W-1:0]  rom [DEPTH];
    logic [LUT_AW-1:0] idx_raw;
    logic [LUT_AW-1:0] idx;
    logic              mirror;

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        assign rom[k] = AMP_W'(she_pkg::quarter_sine(k, DEPTH, AMP_W));
    end

    // Second and fourth quadrants read the table backwards
    assign mirror     = acc_q[PH_W-2];
    assign idx_raw    = acc_q[PH_W-3 -: LUT_AW];
    assign idx        = mirror ? ~idx_raw : idx_raw;
    assign zero_cross = acc_q[PH_W-1] ^ half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mag_q  <= '0;
            half_q <= 1'b0;
        end else begin
            acc_q  <= acc_q + freq_word;
            mag_q  <= rom[idx];
            half_q <= acc_q[PH_W-1];
        end
    end
endmodule

// File: rtl/she_thresh_bank.sv
`timescale 1ns/1ps
module she_thresh_bank #(
    parameter int NCELL  = 2,
    parameter int AMP_W  = 12,
    parameter int ADDR_W = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         thr_we,
    input  logic [ADDR_W-1:0]            thr_addr,
    input  logic [AMP_W-1:0]             thr_data,
    input  logic                         zero_cross,
    output logic [NCELL-1:0][AMP_W-1:0]  lo_act,
    output logic [NCELL-1:0][AMP_W-1:0]  hi_act
);
    localparam int CELL_W = ADDR_W - 1;

    logic [NCELL-1:0][AMP_W-1:0] lo_pend;
    logic [NCELL-1:0][AMP_W-1:0] hi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_pend <= '1;
            hi_pend <= '1;
            lo_act  <= '1;
            hi_act  <= '1;
        end else begin
            for (int c = 0; c < NCELL; c++) begin
                if (thr_we && (thr_addr[ADDR_W-1:1] == CELL_W'(c))) begin
                    if (thr_addr[0]) hi_pend[c] <= thr_data;
                    else             lo_pend[c] <= thr_data;
                end
            end
            // Whole set swaps at once, so one half-cycle never mixes sets
            if (zero_cross) begin
                lo_act <= lo_pend;
                hi_act <= hi_pend;
            end
        end
    end
endmodule

// File: rtl/she_cell_cmp.sv
`timescale 1ns/1ps
module she_cell_cmp #(
    parameter int AMP_W = 12
) (
    input  logic [AMP_W-1:0] mag,
    input  logic [AMP_W-1:0] lo_thr,
    input  logic [AMP_W-1:0] hi_thr,
    input  logic             half,
    output she_pkg::gate_t   gates,
    output logic [1:0]       steps
);
    she_pkg::cmp_t cmp;

    assign cmp.ge_lo = (mag >= lo_thr);
    assign cmp.ge_hi = (mag >= hi_thr);
    assign gates     = she_pkg::gates_of(cmp, half);
    assign steps     = she_pkg::steps_of(cmp);
endmodule

// File: rtl/she_gate_gen.sv
`timescale 1ns/1ps
module she_gate_gen import she_pkg::*; #(
    parameter  int NCELL  = 2,
    parameter  int PH_W   = 32,
    parameter  int LUT_AW = 8,
    parameter  int AMP_W  = 12,
    localparam int CELL_W = (NCELL > 1) ? $clog2(NCELL) : 1,
    localparam int ADDR_W = CELL_W + 1,
    localparam int LVL_W  = $clog2(2 * NCELL + 1) + 1,
    localparam int GATE_W = 5 * NCELL
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         freq_word,
    input  logic                    thr_we,
    input  logic [ADDR_W-1:0]       thr_addr,
    input  logic [AMP_W-1:0]        thr_data,
    output logic [GATE_W-1:0]       cell_gates,
    output logic signed [LVL_W-1:0] level_dbg
);
    logic [AMP_W-1:0]            mag_q;
    logic                        half_q;
    logic                        zero_cross;
    logic [NCELL-1:0][AMP_W-1:0] lo_act;
    logic [NCELL-1:0][AMP_W-1:0] hi_act;
    gate_t [NCELL-1:0]           gates_d;
    gate_t [NCELL-1:0]           gates_q;
    logic [NCELL-1:0][1:0]       steps_d;
    logic signed [LVL_W-1:0]     sum_d;
    logic signed [LVL_W-1:0]     level_d;
    logic signed [LVL_W-1:0]     level_q;

    she_phase_gen #(
        .PH_W   (PH_W),
        .LUT_AW (LUT_AW),
        .AMP_W  (AMP_W)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .mag_q      (mag_q),
        .half_q     (half_q),
        .zero_cross (zero_cross)
    );

    she_thresh_bank #(
        .NCELL  (NCELL),
        .AMP_W  (AMP_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .thr_we     (thr_we),
        .thr_addr   (thr_addr),
        .thr_data   (thr_data),
        .zero_cross (zero_cross),
        .lo_act     (lo_act),
        .hi_act     (hi_act)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        she_cell_cmp #(
            .AMP_W (AMP_W)
        ) u_cmp (
            .mag    (mag_q),
            .lo_thr (lo_act[c]),
            .hi_thr (hi_act[c]),
            .half   (half_q),
            .gates  (gates_d[c]),
            .steps  (steps_d[c])
        );
    end

    always_comb begin
        sum_d = '0;
        for (int c = 0; c < NCELL; c++) begin
            sum_d = sum_d + $signed({{(LVL_W-2){1'b0}}, steps_d[c]});
        end
        level_d = half_q ? -sum_d : sum_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gates_q <= '0;
            level_q <= '0;
        end else begin
            gates_q <= gates_d;
            level_q <= level_d;
        end
    end

    assign cell_gates = gates_q;
    assign level_dbg  = level_q;
endmodule

// File: rtl/she_gate_gen_chk.sv
`timescale 1ns/1ps
module she_gate_gen_chk #(
    parameter int NCELL = 2,
    parameter int AMP_W = 12,
    parameter int LVL_W = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [5*NCELL-1:0]          cell_gates,
    input logic signed [LVL_W-1:0]     level_dbg,
    input logic                        half_q,
    input logic [NCELL-1:0][AMP_W-1:0] lo_act,
    input logic [NCELL-1:0][AMP_W-1:0] hi_act
);
    logic armed = 1'b0;
    logic rst_d = 1'b0;
    logic signed [LVL_W-1:0] lvl_exp;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        armed <= !rst;
    end

    // R9: outputs idle on the sample after a reset edge
    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_idle_R9: assert (cell_gates == '0 && level_dbg == '0)
                else $error("reset idle violated");
        end
    end

    always_comb begin
        int m;
        m = 0;
        for (int c = 0; c < NCELL; c++) begin
            if (cell_gates[5*c+4])                          m = m + 1;
            else if (cell_gates[5*c] || cell_gates[5*c+2])  m = m + 2;
        end
        lvl_exp = cell_gates[3] ? -LVL_W'(m) : LVL_W'(m);
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_chk
        logic s1, s2, s3, s4, s5;
        assign {s5, s4, s3, s2, s1} = cell_gates[5*c +: 5];

        assert_leg_complement_R6: assert property (@(posedge clk) disable iff (rst || !armed)
            (s2 != s4) && (s4 == cell_gates[3]))
            else $error("leg complement violated");

        assert_clamp_exclusive_R5: assert property (@(posedge clk) disable iff (rst || !armed)
            $onehot0({s5, s1, s3}))
            else $error("clamp and full-level switch on together");

        assert_no_shoot_R5: assert property (@(posedge clk) disable iff (rst || !armed)
            !(s1 && s2) && !(s3 && s4))
            else $error("leg shoot-through");
    end

    assert_level_sum_R11: assert property (@(posedge clk) disable iff (rst || !armed)
        level_dbg == lvl_exp)
        else $error("debug level does not match gates");

    assert_thr_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        (half_q == $past(half_q)) |-> ($stable(lo_act) && $stable(hi_act)))
        else $error("thresholds changed inside a half-cycle");
endmodule

bind she_gate_gen she_gate_gen_chk #(
    .NCELL (NCELL),
    .AMP_W (AMP_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_gates (cell_gates),
    .level_dbg  (level_dbg),
    .half_q     (half_q),
    .lo_act     (lo_act),
    .hi_act     (hi_act)
);

// File: tb/she_gate_gen_tb.sv
`timescale 1ns/1ps
module she_gate_gen_tb;
    localparam int NCELL = 2;
    localparam int GW    = 5 * NCELL;
    localparam logic [31:0] F_LOW  = 32'd1952257;  // half period 1100 cycles
    localparam logic [31:0] F_HIGH = 32'd4294966;  // half period about 500 cycles

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] freq_word = '0;
    logic        thr_we = 1'b0;
    logic [1:0]  thr_addr = '0;
    logic [11:0] thr_data = '0;
    logic [GW-1:0]      cell_gates;
    logic signed [3:0]  level_dbg;

    int checks = 0;
    int errors = 0;
    int maxl = 0;
    int minl = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    she_gate_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .thr_we     (thr_we),
        .thr_addr   (thr_addr),
        .thr_data   (thr_data),
        .cell_gates (cell_gates),
        .level_dbg  (level_dbg)
    );

    // Reference model built from R2, R3, R7, R8, R9
    logic [31:0] mp0, mp1, mp2;
    logic        mh;
    logic [11:0] m_lo_p [NCELL];
    logic [11:0] m_hi_p [NCELL];
    logic [11:0] m_lo_a [NCELL];
    logic [11:0] m_hi_a [NCELL];
    logic [11:0] m_lo_d [NCELL];
    logic [11:0] m_hi_d [NCELL];

    always @(posedge clk) begin
        if (rst) begin
            mp0 <= '0; mp1 <= '0; mp2 <= '0; mh <= 1'b0;
            for (int c = 0; c < NCELL; c++) begin
                m_lo_p[c] <= 12'hFFF; m_hi_p[c] <= 12'hFFF;
                m_lo_a[c] <= 12'hFFF; m_hi_a[c] <= 12'hFFF;
                m_lo_d[c] <= 12'hFFF; m_hi_d[c] <= 12'hFFF;
            end
        end else begin
            mp0 <= mp0 + freq_word;
            mp1 <= mp0;
            mp2 <= mp1;
            mh  <= mp0[31];
            if (thr_we) begin
                if (thr_addr[0]) m_hi_p[thr_addr[1]] <= thr_data;
                else             m_lo_p[thr_addr[1]] <= thr_data;
            end
            for (int c = 0; c < NCELL; c++) begin
                if (mp0[31] != mh) begin
                    m_lo_a[c] <= m_lo_p[c];
                    m_hi_a[c] <= m_hi_p[c];
                end
                m_lo_d[c] <= m_lo_a[c];
                m_hi_d[c] <= m_hi_a[c];
            end
        end
    end

    function automatic int sine_mag(input logic [31:0] p);
        longint k, u, r;
        k = longint'(p[29:22]);
        if (p[30]) k = 255 - k;
        u = 2 * k + 1;
        r = (longint'(16) * u * (1024 - u) * 4095) / (longint'(5) * 1024 * 1024 - 4 * u * (1024 - u));
        return int'(r);
    endfunction

    task automatic tally(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int m;
        int lvl;
        logic h;
        bit c1, c2;
        logic [GW-1:0] eg;
        m = sine_mag(mp2);
        h = mp2[31];
        lvl = 0;
        eg = '0;
        for (int c = 0; c < NCELL; c++) begin
            c1 = (m >= int'(m_lo_d[c]));
            c2 = (m >= int'(m_hi_d[c]));
            eg[5*c +: 5] = {c1 && !c2, h, c2 && !h, !h, c2 && h};
            lvl += c2 ? 2 : (c1 ? 1 : 0);
        end
        if (h) lvl = -lvl;
        checks++;
        if (cell_gates !== eg || int'(level_dbg) != lvl) begin
            errors++;
            $display("FAIL %s: actual gates=%h level=%0d expected gates=%h level=%0d",
                     tag, cell_gates, level_dbg, eg, lvl);
        end
        if (int'(level_dbg) > maxl) maxl = int'(level_dbg);
        if (int'(level_dbg) < minl) minl = int'(level_dbg);
    endtask

    task automatic cyc(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            compare(tag);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        thr_we = 1'b1; thr_addr = a; thr_data = d;
        cyc(1, "R8 write cycle");
        thr_we = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        freq_word = F_LOW;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            tally(cell_gates == '0 && level_dbg == '0, "R9 gates idle in reset",
                  int'(cell_gates), 0);
        end
        rst = 1'b0;
        maxl = 0; minl = 0;
        cyc(2300, "R9 R7 default thresholds");
        tally(maxl == 0 && minl == 0, "R9 staircase flat before programming", maxl - minl, 0);
    endtask

    task automatic t_program_run();
        // interleaved: cell0 angles 1 and 3, cell1 angles 2 and 4
        wr(2'd0, 12'd700);
        wr(2'd1, 12'd2900);
        wr(2'd2, 12'd1700);
        wr(2'd3, 12'd3600);
        maxl = 0; minl = 0;
        cyc(4400, "R3 R4 R5 R7 R11 staircase");
        tally(maxl == 4, "R1 positive extreme", maxl, 4);
        tally(minl == -4, "R1 negative extreme", minl, -4);
    endtask

    task automatic t_freq_change();
        int last, nint, bad;
        logic prev;
        freq_word = F_HIGH;
        maxl = 0; minl = 0;
        last = -1; nint = 0; bad = 0;
        prev = cell_gates[3];
        for (int i = 0; i < 2600; i++) begin
            cyc(1, "R10 R7 after frequency change");
            if (cell_gates[3] != prev) begin
                if (last >= 0) begin
                    nint++;
                    if (i - last < 499 || i - last > 502) bad++;
                end
                last = i;
                prev = cell_gates[3];
            end
        end
        tally(nint >= 3 && bad == 0, "R2 half-cycle spacing at new word", bad, 0);
        tally(maxl == 4 && minl == -4, "R10 full staircase kept without rewrite", maxl, 4);
    endtask

    task automatic t_deferred_write();
        logic [GW-1:0] g0;
        logic signed [3:0] l0;
        int diffs, bad;
        freq_word = '0;
        cyc(4, "R8 freeze");
        g0 = cell_gates; l0 = level_dbg;
        wr(2'd1, 12'd0);
        diffs = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1, "R8 pending write");
            if (cell_gates !== g0 || level_dbg !== l0) diffs++;
        end
        tally(diffs == 0, "R8 write without crossing has no effect", diffs, 0);
        freq_word = F_LOW;
        cyc(1400, "R8 write applied at crossing");
        bad = 0;
        for (int i = 0; i < 1000; i++) begin
            cyc(1, "R8 new high threshold");
            if (!(cell_gates[0] || cell_gates[2]) || cell_gates[4]) bad++;
        end
        tally(bad == 0, "R8 cell0 at full step after crossing", bad, 0);
        wr(2'd1, 12'd2900);
        cyc(2300, "R8 restore");
    endtask

    task automatic t_inverted_pair();
        int s5_cnt, full_cnt;
        wr(2'd2, 12'd3600);
        wr(2'd3, 12'd1700);
        cyc(1200, "R4 inverted pair settle");
        s5_cnt = 0; full_cnt = 0;
        for (int i = 0; i < 2200; i++) begin
            cyc(1, "R4 inverted pair");
            if (cell_gates[9]) s5_cnt++;
            if (cell_gates[5] || cell_gates[7]) full_cnt++;
        end
        tally(s5_cnt == 0, "R4 no half step when high below low", s5_cnt, 0);
        tally(full_cnt > 0, "R4 full step from high threshold", full_cnt, 1);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            tally(cell_gates == '0 && level_dbg == '0, "R9 gates idle in second reset",
                  int'(cell_gates), 0);
        end
        rst = 1'b0;
        maxl = 0; minl = 0;
        cyc(2300, "R9 after second reset");
        tally(maxl == 0 && minl == 0, "R9 thresholds back to maximum", maxl - minl, 0);
    endtask

    initial begin
        t_reset_state();
        t_program_run();
        t_freq_change();
        t_deferred_write();
        t_inverted_pair();
        t_reset_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule